// File: doc/BRIEF.md
# Linked-Load Reservation Register (Requester Side)

This unit sits between a processor core and the memory network. It holds one linked-load reservation: a physical address, the authentication key issued for that address by memory, a lifetime counter and a valid bit. The core sends it linked-load, store-conditional and plain-store requests. For each request the unit decides whether a network command is needed and how many flits that command has. It hands the command out as a descriptor and waits for the single memory response that belongs to it.

A store-conditional whose address does not match a live reservation fails at once inside the unit, with no network traffic. A plain store to the reserved address kills the reservation. Other stores leave it alone, and every store still goes to memory. A reservation lasts for exactly `2**LIFE_W` cycles after it is recorded. Memory reports a store-conditional outcome as 0 for success and 1 for failure. A configuration input decides whether that code is passed to the core as it is, or inverted so that nonzero means success. A failure decided locally goes through the same translation.

Top module: `llrsv_unit`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `cmd_valid` and `rsp_valid` are 0, and no reservation is held, so a store-conditional fails locally.
- R2: An accepted linked-load (`req_op`=0) raises `cmd_valid` in the next cycle with `cmd_kind`=1, `cmd_flits`=1 and `cmd_addr` equal to the request address.
- R3: When the linked-load response arrives, the response address and `mem_key` are recorded as a valid reservation, and the core gets `rsp_data` equal to `mem_data`.
- R4: An accepted store-conditional (`req_op`=1) that misses a valid reservation, whether none is held or the address differs, raises no command. In the next cycle it raises `rsp_valid` with the failure code.
- R5: A store-conditional that hits issues `cmd_kind`=2 with `cmd_flits`=2, carrying the address, the stored key and the write data. It also clears the reservation, so a repeated store-conditional fails locally.
- R6: A plain store (`req_op`=2) always issues `cmd_kind`=3 with `cmd_flits`=1, carrying the address and data, and gets `rsp_data`=0. It clears the reservation only if its address equals the reserved one.
- R7: A reservation recorded at clock edge E is still honoured by a store-conditional accepted at edge E+2**LIFE_W. At edge E+2**LIFE_W+1 it is gone.
- R8: If a linked-load response records a reservation on the same edge at which the old one times out, the new reservation is kept.
- R9: The store-conditional status comes from bit 0 of `mem_data`. It is returned in bit 0 of `rsp_data`, unchanged when `cfg_succ_nonzero`=0 and inverted when it is 1. A local failure is returned as code 1 passed through the same rule.
- R10: Only one request is in flight. `req_ready` is low from the accepting edge until the cycle after the single `rsp_valid` cycle.
- R11: While `cmd_valid` is high and `cmd_ready` is low, the command stays valid with all of its fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_succ_nonzero | input | 1 | 1: core expects nonzero for success |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_op | input | 2 | 0 linked-load, 1 store-conditional, 2 store (3 acts as a store) |
| req_addr | input | ADDR_W | Physical address |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle response to the core |
| rsp_data | output | DATA_W | Load data, translated status, or 0 |
| cmd_valid | output | 1 | Network command descriptor valid |
| cmd_ready | input | 1 | Network accepts the descriptor |
| cmd_kind | output | 2 | 1 linked-load, 2 store-conditional, 3 write |
| cmd_flits | output | 2 | Flit count of the command |
| cmd_addr | output | ADDR_W | Command address |
| cmd_key | output | KEY_W | Reservation key (store-conditional only, else 0) |
| cmd_wdata | output | DATA_W | Write data (0 for linked-load) |
| mem_valid | input | 1 | Memory response strobe |
| mem_data | input | DATA_W | Read data or status code in bit 0 |
| mem_key | input | KEY_W | Key issued for a linked-load |

## Verification
Two things can happen on the same edge as the timeout of the lifetime counter: a store-conditional can be accepted, and a fresh linked-load response can be recorded. The bench keeps its own edge count, with `LIFE_W` made small. It lands a store-conditional exactly on the last honoured edge and one edge later, and checks that the first leaves as a two-flit command while the second fails locally. It then holds back a memory response so that it lands on the timeout edge, and judges that the new reservation survived by issuing a store-conditional that must hit.

// File: rtl/llrsv_pkg.sv
package llrsv_pkg;

    typedef enum logic [1:0] {
        OP_LL  = 2'd0,
        OP_SC  = 2'd1,
        OP_ST  = 2'd2,
        OP_ST3 = 2'd3
    } core_op_e;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_LL   = 2'd1,
        CK_SC   = 2'd2,
        CK_WR   = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RESP
    } fsm_state_e;

    localparam logic [1:0] FLITS_ONE = 2'd1;
    localparam logic [1:0] FLITS_TWO = 2'd2;

    localparam logic MEM_FAIL = 1'b1;

    // memory code 0 = success; invert when the core wants nonzero = success
    function automatic logic core_status(input logic mem_code, input logic nz_ok);
        return mem_code ^ nz_ok;
    endfunction

endpackage

// File: rtl/llrsv_store.sv
module llrsv_store #(
    parameter int ADDR_W = 40,
    parameter int KEY_W  = 32,
    parameter int LIFE_W = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic [ADDR_W-1:0] set_addr_i,
    input  logic [KEY_W-1:0]  set_key_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] probe_addr_i,
    output logic              hit_o,
    output logic [KEY_W-1:0]  key_o
);
    localparam logic [LIFE_W-1:0] AGE_LAST = {LIFE_W{1'b1}};

    logic              valid_q;
    logic [ADDR_W-1:0] addr_q;
    logic [KEY_W-1:0]  key_q;
    logic [LIFE_W-1:0] age_q;

    assign hit_o = valid_q && (addr_q == probe_addr_i);
    assign key_o = key_q;

    // priority: new reservation > explicit clear > timeout
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            key_q   <= '0;
            age_q   <= '0;
        end else if (set_i) begin
            valid_q <= 1'b1;
            addr_q  <= set_addr_i;
            key_q   <= set_key_i;
            age_q   <= '0;
        end else if (clr_i) begin
            valid_q <= 1'b0;
        end else if (valid_q) begin
            if (age_q == AGE_LAST) begin
                valid_q <= 1'b0;
            end
            age_q <= age_q + 1'b1;
        end
    end

    AST_SET_FRESH: assert property (@(posedge clk) disable iff (rst)
        set_i |=> (valid_q && age_q == '0 && key_q == $past(set_key_i))) else $error("set"); // R3
    AST_AGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (valid_q && age_q == AGE_LAST && !set_i) |=> !valid_q) else $error("age"); // R7
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !valid_q) else $error("clr"); // R5
endmodule

// File: rtl/llrsv_ctrl.sv
module llrsv_ctrl
    import llrsv_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int KEY_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_succ_nonzero,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [1:0]        cmd_flits,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [KEY_W-1:0]  cmd_key,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [KEY_W-1:0]  mem_key,
    input  logic              resv_hit,
    input  logic [KEY_W-1:0]  resv_key,
    output logic              resv_set,
    output logic [ADDR_W-1:0] resv_set_addr,
    output logic [KEY_W-1:0]  resv_set_key,
    output logic              resv_clr
);
    typedef struct packed {
        cmd_kind_e         kind;
        logic [1:0]        flits;
        logic [ADDR_W-1:0] addr;
        logic [KEY_W-1:0]  key;
        logic [DATA_W-1:0] data;
    } cmd_desc_t;

    fsm_state_e        state_q;
    core_op_e          op_q;
    core_op_e          op_in;
    cmd_desc_t         cmd_q;
    logic [DATA_W-1:0] rsp_q;
    logic              accept;

    assign op_in  = core_op_e'(req_op);
    assign accept = req_valid && (state_q == ST_IDLE);

    assign req_ready = (state_q == ST_IDLE);
    assign cmd_valid = (state_q == ST_SEND);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_data  = rsp_q;
    assign cmd_kind  = cmd_q.kind;
    assign cmd_flits = cmd_q.flits;
    assign cmd_addr  = cmd_q.addr;
    assign cmd_key   = cmd_q.key;
    assign cmd_wdata = cmd_q.data;

    assign resv_clr      = accept && (op_in != OP_LL) && resv_hit;
    assign resv_set      = (state_q == ST_WAIT) && mem_valid && (op_q == OP_LL);
    assign resv_set_addr = cmd_q.addr;
    assign resv_set_key  = mem_key;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_LL;
            cmd_q   <= '0;
            rsp_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q       <= op_in;
                        cmd_q.addr <= req_addr;
                        case (op_in)
                            OP_LL: begin
                                state_q     <= ST_SEND;
                                cmd_q.kind  <= CK_LL;
                                cmd_q.flits <= FLITS_ONE;
                                cmd_q.key   <= '0;
                                cmd_q.data  <= '0;
                            end
                            OP_SC: begin
                                if (resv_hit) begin
                                    state_q     <= ST_SEND;
                                    cmd_q.kind  <= CK_SC;
                                    cmd_q.flits <= FLITS_TWO;
                                    cmd_q.key   <= resv_key;
                                    cmd_q.data  <= req_wdata;
                                end else begin
                                    state_q <= ST_RESP;
                                    rsp_q   <= {{(DATA_W-1){1'b0}},
                                                core_status(MEM_FAIL, cfg_succ_nonzero)};
                                end
                            end
                            default: begin
                                state_q     <= ST_SEND;
                                cmd_q.kind  <= CK_WR;
                                cmd_q.flits <= FLITS_ONE;
                                cmd_q.key   <= '0;
                                cmd_q.data  <= req_wdata;
                            end
                        endcase
                    end
                end
                ST_SEND: begin
                    if (cmd_ready) begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_valid) begin
                        state_q <= ST_RESP;
                        case (op_q)
                            OP_LL:   rsp_q <= mem_data;
                            OP_SC:   rsp_q <= {{(DATA_W-1){1'b0}},
                                               core_status(mem_data[0], cfg_succ_nonzero)};
                            default: rsp_q <= '0;
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_kind)
                                       && $stable(cmd_key) && $stable(cmd_wdata))) else $error("hold"); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid) else $error("pulse"); // R10
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid || cmd_valid) |-> !req_ready) else $error("busy"); // R10
    AST_SC_MISS_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (accept && op_in == OP_SC && !resv_hit) |=> (rsp_valid && !cmd_valid)) else $error("miss"); // R4
    AST_SC_TWO_FLITS: assert property (@(posedge clk) disable iff (rst)
        (accept && op_in == OP_SC && resv_hit) |=> (cmd_valid && cmd_flits == 2'd2)) else $error("sc"); // R5
endmodule

// File: rtl/llrsv_unit.sv
module llrsv_unit #(
    parameter int ADDR_W = 40,
    parameter int KEY_W  = 32,
    parameter int DATA_W = 32,
    parameter int LIFE_W = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_succ_nonzero,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic [1:0]        cmd_flits,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [KEY_W-1:0]  cmd_key,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [KEY_W-1:0]  mem_key
);
    logic              resv_hit;
    logic [KEY_W-1:0]  resv_key;
    logic              resv_set;
    logic [ADDR_W-1:0] resv_set_addr;
    logic [KEY_W-1:0]  resv_set_key;
    logic              resv_clr;

    llrsv_ctrl #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst(rst), .cfg_succ_nonzero(cfg_succ_nonzero),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_flits(cmd_flits), .cmd_addr(cmd_addr), .cmd_key(cmd_key),
        .cmd_wdata(cmd_wdata),
        .mem_valid(mem_valid), .mem_data(mem_data), .mem_key(mem_key),
        .resv_hit(resv_hit), .resv_key(resv_key), .resv_set(resv_set),
        .resv_set_addr(resv_set_addr), .resv_set_key(resv_set_key),
        .resv_clr(resv_clr)
    );

    llrsv_store #(.ADDR_W(ADDR_W), .KEY_W(KEY_W), .LIFE_W(LIFE_W)) u_store (
        .clk(clk), .rst(rst),
        .set_i(resv_set), .set_addr_i(resv_set_addr), .set_key_i(resv_set_key),
        .clr_i(resv_clr), .probe_addr_i(req_addr),
        .hit_o(resv_hit), .key_o(resv_key)
    );
endmodule

// File: tb/tb_llrsv_unit.sv
module tb_llrsv_unit;
    localparam int AW = 40;
    localparam int KW = 32;
    localparam int DW = 32;
    localparam int LW = 4;
    localparam int LIFE = 1 << LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          cmd_valid;
    logic          cmd_ready = 1'b1;
    logic [1:0]    cmd_kind;
    logic [1:0]    cmd_flits;
    logic [AW-1:0] cmd_addr;
    logic [KW-1:0] cmd_key;
    logic [DW-1:0] cmd_wdata;
    logic          mem_valid = 1'b0;
    logic [DW-1:0] mem_data = '0;
    logic [KW-1:0] mem_key = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    llrsv_unit #(.ADDR_W(AW), .KEY_W(KW), .DATA_W(DW), .LIFE_W(LW)) dut (
        .clk(clk), .rst(rst), .cfg_succ_nonzero(cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_flits(cmd_flits), .cmd_addr(cmd_addr), .cmd_key(cmd_key),
        .cmd_wdata(cmd_wdata),
        .mem_valid(mem_valid), .mem_data(mem_data), .mem_key(mem_key)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic go_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // present a request at a negedge; returns at the negedge after the accepting edge
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic mem_reply(input logic [DW-1:0] d, input logic [KW-1:0] k);
        mem_valid = 1'b1; mem_data = d; mem_key = k;
        @(negedge clk);
        mem_valid = 1'b0;
    endtask

    // linked-load; set_cyc gets the edge at which the reservation is recorded
    task automatic do_ll(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [KW-1:0] k,
                         input int land, output int set_cyc);
        issue(2'd0, a, '0);
        check(cmd_valid && cmd_kind == 2'd1 && cmd_flits == 2'd1, "R2", "LL kind/flits",
              {cmd_valid, cmd_kind, cmd_flits}, {1'b1, 2'd1, 2'd1});
        check(cmd_addr == a, "R2", "LL addr", cmd_addr, a);
        @(negedge clk);
        if (land > 0) go_cyc(land - 1);
        mem_reply(d, k);
        set_cyc = cyc;
        check(rsp_valid && rsp_data == d, "R3", "LL data", rsp_data, d);
        check(!req_ready, "R10", "ready low during rsp", req_ready, 0);
        @(negedge clk);
        check(req_ready && !rsp_valid, "R10", "ready back", {req_ready, rsp_valid}, 2'b10);
    endtask

    task automatic do_sc_hit(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [KW-1:0] k,
                             input logic code, input logic [DW-1:0] exp, input string req);
        issue(2'd1, a, d);
        check(cmd_valid && cmd_kind == 2'd2 && cmd_flits == 2'd2, req, "SC cmd",
              {cmd_valid, cmd_kind, cmd_flits}, {1'b1, 2'd2, 2'd2});
        check(cmd_addr == a && cmd_key == k && cmd_wdata == d, "R5", "SC payload", cmd_key, k);
        @(negedge clk);
        mem_reply({{(DW-1){1'b0}}, code}, '0);
        check(rsp_valid && rsp_data == exp, "R9", "SC status", rsp_data, exp);
        @(negedge clk);
    endtask

    task automatic do_sc_local(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        issue(2'd1, a, 32'hDEAD);
        check(!cmd_valid && rsp_valid, req, "SC local fail", {cmd_valid, rsp_valid}, 2'b01);
        check(rsp_data == exp, "R9", "local status", rsp_data, exp);
        @(negedge clk);
    endtask

    task automatic do_st(input logic [AW-1:0] a, input logic [DW-1:0] d);
        issue(2'd2, a, d);
        check(cmd_valid && cmd_kind == 2'd3 && cmd_flits == 2'd1 && cmd_addr == a && cmd_wdata == d,
              "R6", "store cmd", {cmd_kind, cmd_flits}, {2'd3, 2'd1});
        @(negedge clk);
        mem_reply('0, '0);
        check(rsp_valid && rsp_data == '0, "R6", "store ack", rsp_data, 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(req_ready && !cmd_valid && !rsp_valid, "R1", "reset outputs",
              {req_ready, cmd_valid, rsp_valid}, 3'b100);
        do_sc_local(40'h12_0000_0040, 32'd1, "R1");
    endtask

    task automatic t_basic();
        int s;
        cfg = 1'b0;
        do_ll(40'hA5_0000_1000, 32'h1111_2222, 32'hC0DE_0001, 0, s);
        do_sc_hit(40'hA5_0000_1000, 32'h0000_0001, 32'hC0DE_0001, 1'b0, 32'd0, "R5");
        do_sc_local(40'hA5_0000_1000, 32'd1, "R5");
        do_ll(40'hA5_0000_2000, 32'h5, 32'hC0DE_0002, 0, s);
        do_sc_local(40'hA5_0000_2004, 32'd1, "R4");
        do_sc_hit(40'hA5_0000_2000, 32'h7, 32'hC0DE_0002, 1'b1, 32'd1, "R9");
    endtask

    task automatic t_store();
        int s;
        do_ll(40'h0F_0000_0100, 32'h9, 32'h0000_0ABC, 0, s);
        do_st(40'h0F_0000_0200, 32'h77);
        do_sc_hit(40'h0F_0000_0100, 32'h3, 32'h0000_0ABC, 1'b0, 32'd0, "R6");
        do_ll(40'h0F_0000_0100, 32'h9, 32'h0000_0ABD, 0, s);
        do_st(40'h0F_0000_0100, 32'h88);
        do_sc_local(40'h0F_0000_0100, 32'd1, "R6");
    endtask

    task automatic t_xcode();
        int s;
        cfg = 1'b1;
        do_ll(40'h33_0000_0000, 32'h1, 32'h5555_0000, 0, s);
        do_sc_hit(40'h33_0000_0000, 32'h2, 32'h5555_0000, 1'b0, 32'd1, "R9");
        do_sc_local(40'h33_0000_0000, 32'd0, "R9");
        do_ll(40'h33_0000_0000, 32'h1, 32'h5555_0001, 0, s);
        do_sc_hit(40'h33_0000_0000, 32'h2, 32'h5555_0001, 1'b1, 32'd0, "R9");
        cfg = 1'b0;
    endtask

    task automatic t_hold();
        logic [AW-1:0] a;
        a = 40'h44_1234_5678;
        cmd_ready = 1'b0;
        issue(2'd2, a, 32'hBEEF);
        repeat (3) begin
            @(negedge clk);
            check(cmd_valid && cmd_addr == a && cmd_wdata == 32'hBEEF && cmd_kind == 2'd3,
                  "R11", "held cmd", cmd_addr, a);
            check(!req_ready, "R10", "busy while held", req_ready, 0);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        check(!cmd_valid, "R11", "cmd taken", cmd_valid, 0);
        mem_reply('0, '0);
        check(rsp_valid, "R10", "store rsp", rsp_valid, 1);
        @(negedge clk);
    endtask

    task automatic t_life();
        int e;
        do_ll(40'h70_0000_0000, 32'h0, 32'hAAAA_0001, 0, e);
        go_cyc(e + LIFE - 1);
        do_sc_hit(40'h70_0000_0000, 32'h1, 32'hAAAA_0001, 1'b0, 32'd0, "R7");
        do_ll(40'h70_0000_0000, 32'h0, 32'hAAAA_0002, 0, e);
        go_cyc(e + LIFE);
        do_sc_local(40'h70_0000_0000, 32'd1, "R7");
    endtask

    task automatic t_refill();
        int e;
        int s;
        do_ll(40'h71_0000_0000, 32'h0, 32'hBBBB_0001, 0, e);
        do_ll(40'h72_0000_0000, 32'h0, 32'hBBBB_0002, e + LIFE, s);
        check(s == e + LIFE, "R8", "refill edge", s, e + LIFE);
        do_sc_hit(40'h72_0000_0000, 32'h4, 32'hBBBB_0002, 1'b0, 32'd0, "R8");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_store();
        t_xcode();
        t_hold();
        t_life();
        t_refill();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule